// File: doc/BRIEF.md
# Message Buffer Interrupt Flag Unit

This block keeps one completion flag for each of the 64 message buffers of a CAN-style controller. The buffer engine sends a one-cycle completion pulse whenever a buffer finishes a successful transmit or receive, and the matching flag is set. Software reads the flags through a small register port as two 32-bit words and clears them by writing ones. Writing zero to a bit leaves that bit unchanged. A per-flag mask input decides which flags drive the single level interrupt output.

Two mode inputs change how the low word behaves. In FIFO mode the eight lowest flags stop recording buffer completions. Three of them record FIFO status events instead, and the five below those are hidden. In abort mode, a pending flag on a buffer set up for transmit raises that buffer's write-block output. The buffer memory uses this output to refuse CPU writes to that buffer.

Top module: `mbf_unit`

## Requirements
- R1: After reset every flag is 0, so reads at 0x2C and 0x30 return 0, `irq` is 0 and `wr_block` is 0.
- R2: A 1 on `done[n]` at a clock edge sets flag n for the next cycle. Flags 63..32 appear at offset 0x2C as bit n-32, and flags 31..0 appear at offset 0x30 as bit n.
- R3: A write to 0x2C or 0x30 clears every flag whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R4: If a set and a write-one-to-clear reach the same flag in the same cycle, the flag ends up 1.
- R5: `irq` is 1 exactly when some visible flag is 1 and its `mask` bit is 1.
- R6: With `fifo_en` = 1, `fifo_evt[0]`, `fifo_evt[1]` and `fifo_evt[2]` set flags 5, 6 and 7, and `done[7:0]` has no effect.
- R7: With `fifo_en` = 1, bits 4..0 of the 0x30 word read 0 and do not count toward `irq`. Their stored values are kept and show again once `fifo_en` returns to 0.
- R8: Clearing `fifo_en` leaves flags 7..5 unchanged until software clears them.
- R9: `wr_block[n]` is `abort_en & buf_tx[n] & flag n`. In FIFO mode, `wr_block[7:0]` is 0.
- R10: A read at any address other than 0x2C or 0x30 returns 0, and a write there changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en | input | 1 | FIFO mode select |
| abort_en | input | 1 | Abort mode select |
| done | input | 64 | Per-buffer completion pulses |
| fifo_evt | input | 3 | FIFO status event pulses |
| buf_tx | input | 64 | 1 = buffer configured for transmit |
| mask | input | 64 | Per-flag interrupt enable |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data, 1 clears the bit |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt level |
| wr_block | output | 64 | Per-buffer CPU write inhibit |

## Verification
The bench sweeps all 64 buffers. For each one it sets the flag, checks the bit position in the right word, checks gating by the mask, and checks write-block in abort mode. It also checks that a write of zero leaves the flag alone and that a write of one clears it. A design that swapped the two offsets, or counted bit positions from the wrong end, would fail on the first buffer of each word. A clear that beat a same-cycle set would lose a completion, and the bench checks for exactly that collision. The FIFO checks confirm that masked completions are ignored, that the five hidden bits are not lost, and that status bits survive the exit from FIFO mode. A design that wiped flags on a mode change would fail these.

// File: rtl/mbf_pkg.sv
package mbf_pkg;
  // Byte offset of register idx; the highest index sits at base, lower ones follow every 4 bytes.
  function automatic int reg_offset(input int idx, input int nreg, input int base);
    return base + 4 * (nreg - 1 - idx);
  endfunction

  // Mask with the low n bits set, for a vector of width w (w <= 64).
  function automatic logic [63:0] low_ones(input int n);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 64; i++) if (i < n) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/mbf_flag_reg.sv
module mbf_flag_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_vec) | set_vec;
  end

  assert_set_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((flags & $past(set_vec)) == $past(set_vec)));
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~set_vec)) |=> ((flags & $past(clr_vec & ~set_vec)) == '0));
  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(set_vec)) == '0));
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_vec & clr_vec)) |=> ((flags & $past(set_vec & clr_vec)) == $past(set_vec & clr_vec)));
endmodule

// File: rtl/mbf_event_map.sv
module mbf_event_map #(
  parameter int NUM_BUF = 64,
  parameter int EVT_W   = 3,
  parameter int RSVD_W  = 5
) (
  input  logic               fifo_en,
  input  logic [NUM_BUF-1:0] done,
  input  logic [EVT_W-1:0]   fifo_evt,
  output logic [NUM_BUF-1:0] set_vec
);
  localparam int SPAN = EVT_W + RSVD_W;

  always_comb begin
    set_vec = done;
    if (fifo_en) set_vec[SPAN-1:0] = {fifo_evt, {RSVD_W{1'b0}}};
  end
endmodule

// File: rtl/mbf_view.sv
module mbf_view #(
  parameter int NUM_BUF = 64,
  parameter int EVT_W   = 3,
  parameter int RSVD_W  = 5
) (
  input  logic               fifo_en,
  input  logic               abort_en,
  input  logic [NUM_BUF-1:0] flags,
  input  logic [NUM_BUF-1:0] mask,
  input  logic [NUM_BUF-1:0] buf_tx,
  output logic [NUM_BUF-1:0] visible,
  output logic               irq,
  output logic [NUM_BUF-1:0] wr_block
);
  import mbf_pkg::*;
  localparam int SPAN = EVT_W + RSVD_W;
  localparam logic [NUM_BUF-1:0] RSVD_MASK = NUM_BUF'(low_ones(RSVD_W));
  localparam logic [NUM_BUF-1:0] SPAN_MASK = NUM_BUF'(low_ones(SPAN));

  logic [NUM_BUF-1:0] tx_region;

  always_comb begin
    visible   = fifo_en ? (flags & ~RSVD_MASK) : flags;
    tx_region = fifo_en ? ~SPAN_MASK : '1;
    irq       = |(visible & mask);
    wr_block  = abort_en ? (flags & buf_tx & tx_region) : '0;
  end
endmodule

// File: rtl/mbf_bus_decode.sv
module mbf_bus_decode #(
  parameter int NUM_REG  = 2,
  parameter int REG_W    = 32,
  parameter int ADDR_W   = 8,
  parameter int BASE_OFS = 'h2C
) (
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic [REG_W-1:0]         bus_wdata,
  input  logic [NUM_REG*REG_W-1:0] visible,
  output logic [NUM_REG*REG_W-1:0] clr_vec,
  output logic [REG_W-1:0]         bus_rdata
);
  import mbf_pkg::*;

  logic [NUM_REG-1:0] hit;

  for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
    assign hit[g] = (bus_addr == ADDR_W'(reg_offset(g, NUM_REG, BASE_OFS)));
    assign clr_vec[g*REG_W +: REG_W] = (bus_wr && hit[g]) ? bus_wdata : '0;
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_REG; i++)
      if (hit[i]) bus_rdata = visible[i*REG_W +: REG_W];
  end
endmodule

// File: rtl/mbf_unit.sv
module mbf_unit #(
  parameter int NUM_BUF  = 64,
  parameter int REG_W    = 32,
  parameter int ADDR_W   = 8,
  parameter int BASE_OFS = 'h2C,
  parameter int EVT_W    = 3,
  parameter int RSVD_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fifo_en,
  input  logic               abort_en,
  input  logic [NUM_BUF-1:0] done,
  input  logic [EVT_W-1:0]   fifo_evt,
  input  logic [NUM_BUF-1:0] buf_tx,
  input  logic [NUM_BUF-1:0] mask,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  output logic               irq,
  output logic [NUM_BUF-1:0] wr_block
);
  import mbf_pkg::*;
  localparam int NUM_REG = NUM_BUF / REG_W;
  localparam logic [ADDR_W-1:0] LO_OFS = ADDR_W'(reg_offset(0, NUM_REG, BASE_OFS));

  logic [NUM_BUF-1:0] set_vec, clr_vec, flags, visible;

  mbf_event_map #(.NUM_BUF(NUM_BUF), .EVT_W(EVT_W), .RSVD_W(RSVD_W)) u_map (
    .fifo_en(fifo_en), .done(done), .fifo_evt(fifo_evt), .set_vec(set_vec));

  for (genvar g = 0; g < NUM_REG; g++) begin : g_flag
    mbf_flag_reg #(.W(REG_W)) u_reg (
      .clk(clk), .rst_n(rst_n),
      .set_vec(set_vec[g*REG_W +: REG_W]),
      .clr_vec(clr_vec[g*REG_W +: REG_W]),
      .flags(flags[g*REG_W +: REG_W]));
  end

  mbf_view #(.NUM_BUF(NUM_BUF), .EVT_W(EVT_W), .RSVD_W(RSVD_W)) u_view (
    .fifo_en(fifo_en), .abort_en(abort_en), .flags(flags), .mask(mask),
    .buf_tx(buf_tx), .visible(visible), .irq(irq), .wr_block(wr_block));

  mbf_bus_decode #(.NUM_REG(NUM_REG), .REG_W(REG_W), .ADDR_W(ADDR_W),
                   .BASE_OFS(BASE_OFS)) u_dec (
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .visible(visible), .clr_vec(clr_vec), .bus_rdata(bus_rdata));

  assert_irq_needs_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|mask));
  assert_fifo_low_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && bus_addr == LO_OFS) |-> (bus_rdata[RSVD_W-1:0] == '0));
  assert_block_tx_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_block & ~buf_tx) == '0));
  assert_block_needs_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!abort_en) |-> (wr_block == '0));
endmodule

// File: tb/mbf_unit_bench.sv
module mbf_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] HI = 8'h2C;
  localparam logic [7:0] LO = 8'h30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_en = 1'b0, abort_en = 1'b0, bus_wr = 1'b0;
  logic [63:0] done = '0, buf_tx = '0, mask = '0, wr_block;
  logic [2:0]  fifo_evt = '0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        irq;

  logic [63:0] model = '0;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbf_unit u_mbf_unit (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .abort_en(abort_en),
    .done(done), .fifo_evt(fifo_evt), .buf_tx(buf_tx), .mask(mask),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .wr_block(wr_block));

  function automatic logic [63:0] shown();
    return fifo_en ? (model & ~64'h1F) : model;
  endfunction

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", what, act, exp);
    end
  endtask

  // One clock with the given stimulus; the model follows the requirements.
  task automatic step(input logic [63:0] d, input logic [2:0] e,
                      input logic w, input logic [7:0] a, input logic [31:0] wd);
    logic [63:0] s, c;
    @(negedge clk);
    done = d; fifo_evt = e; bus_wr = w; bus_addr = a; bus_wdata = wd;
    @(posedge clk);
    s = fifo_en ? {d[63:8], e, 5'b0} : d;
    c = '0;
    if (w && a == HI) c[63:32] = wd;
    if (w && a == LO) c[31:0]  = wd;
    model = (model & ~c) | s;
    #1;
    done = '0; fifo_evt = '0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input string what);
    logic [63:0] v;
    logic [31:0] exp;
    @(negedge clk);
    bus_addr = a;
    #1;
    v = shown();
    exp = (a == HI) ? v[63:32] : (a == LO) ? v[31:0] : 32'h0;
    chk(64'(bus_rdata), 64'(exp), what);
  endtask

  task automatic chk_irq(input string what);
    @(negedge clk); #1;
    chk(64'(irq), 64'(|(shown() & mask)), what);
  endtask

  task automatic chk_blk(input string what);
    logic [63:0] exp;
    @(negedge clk); #1;
    exp = abort_en ? (model & buf_tx & (fifo_en ? ~64'hFF : ~64'h0)) : 64'h0;
    chk(wr_block, exp, what);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    rd(HI, "R1 high word after reset");
    rd(LO, "R1 low word after reset");
    chk(64'(irq), 64'h0, "R1 irq after reset");
    chk(wr_block, 64'h0, "R1 wr_block after reset");
    @(negedge clk) rst_n = 1'b1;

    // Sweep every buffer: R2 set, R5 mask, R9 block, R3 clear.
    for (int i = 0; i < 64; i++) begin
      logic [7:0] a;
      logic [31:0] b;
      a = (i >= 32) ? HI : LO;
      b = 32'h1 << (i % 32);
      step(64'h1 << i, 3'b0, 1'b0, 8'h0, 32'h0);
      rd(a, $sformatf("R2 buffer %0d position", i));
      mask = ~(64'h1 << i);
      chk_irq($sformatf("R5 buffer %0d masked off", i));
      mask = 64'h1 << i;
      chk_irq($sformatf("R5 buffer %0d masked on", i));
      buf_tx = 64'h1 << i; abort_en = 1'b0;
      chk_blk($sformatf("R9 buffer %0d no abort", i));
      abort_en = 1'b1;
      chk_blk($sformatf("R9 buffer %0d tx pending", i));
      buf_tx = ~(64'h1 << i);
      chk_blk($sformatf("R9 buffer %0d rx pending", i));
      step(64'h0, 3'b0, 1'b1, a, ~b);
      rd(a, $sformatf("R3 buffer %0d zero write keeps", i));
      step(64'h0, 3'b0, 1'b1, 8'h40, 32'hFFFF_FFFF);
      rd(a, $sformatf("R10 buffer %0d stray write ignored", i));
      step(64'h0, 3'b0, 1'b1, a, b);
      rd(a, $sformatf("R3 buffer %0d cleared", i));
      chk_irq($sformatf("R5 buffer %0d irq drops", i));
      abort_en = 1'b0; buf_tx = '0;
    end
    mask = '1;

    // R4: set and clear collide
    step(64'h0000_0001_8000_0001, 3'b0, 1'b1, LO, 32'hFFFF_FFFF);
    rd(LO, "R4 set wins low word");
    rd(HI, "R4 other word untouched");
    step(64'h0, 3'b0, 1'b1, HI, 32'hFFFF_FFFF);
    step(64'h0, 3'b0, 1'b1, LO, 32'hFFFF_FFFF);
    rd(LO, "R3 all cleared");

    // R10: unmapped read
    step(64'hFFFF_FFFF_FFFF_FFFF, 3'b0, 1'b0, 8'h0, 32'h0);
    rd(8'h34, "R10 unmapped read 0x34");
    rd(8'h28, "R10 unmapped read 0x28");
    step(64'h0, 3'b0, 1'b1, HI, 32'hFFFF_FFFF);
    step(64'h0, 3'b0, 1'b1, LO, 32'hFFFF_FFFF);

    // R7: hidden bits keep storage
    step(64'h4, 3'b0, 1'b0, 8'h0, 32'h0);
    fifo_en = 1'b1; mask = 64'h4;
    rd(LO, "R7 bit 2 hidden in fifo mode");
    chk_irq("R7 hidden bit gives no irq");
    // R6: completions on 7..0 ignored, events mapped
    step(64'hC9, 3'b000, 1'b0, 8'h0, 32'h0);
    rd(LO, "R6 done[7:0] ignored");
    step(64'h0, 3'b101, 1'b0, 8'h0, 32'h0);
    rd(LO, "R6 events set bits 7 and 5");
    step(64'h0, 3'b010, 1'b0, 8'h0, 32'h0);
    rd(LO, "R6 event 1 sets bit 6");
    mask = 64'h80;
    chk_irq("R5 fifo status irq");
    abort_en = 1'b1; buf_tx = 64'hFF;
    chk_blk("R9 fifo span not blocked");
    abort_en = 1'b0; buf_tx = '0;
    // R8: exit keeps status, hidden bit returns
    fifo_en = 1'b0;
    rd(LO, "R8 status kept after exit, R7 bit 2 back");
    mask = 64'h4;
    chk_irq("R7 restored bit drives irq");
    step(64'h0, 3'b0, 1'b1, LO, 32'hA0);
    rd(LO, "R3 partial clear of status");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule